// File: doc/BRIEF.md
# Atomic Parameter Safeload Controller

This block holds a small set of pending parameter updates for a DSP core's parameter RAM and writes them as a group. The host control interface loads each update into a staging slot. A slot is an address register and a data register. The host then requests a transfer by setting an initiate bit. The block does not write to the RAM at once. It waits for the start of the next audio frame. It then uses the spare instruction cycles at the end of that frame's program, after the core has finished its own work. All staged values therefore take effect between two frames. A filter never runs one frame with a mix of old and new coefficients.

Only slots whose data register was written since the last transfer are sent to the RAM. Any other slot is skipped, whatever it holds. A busy flag covers the time from the initiate request to the last RAM write. While that flag is high, host writes are dropped, so the staged set cannot change under the transfer. The frame program must leave the last cycles of each frame free, one cycle per slot.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset, `busy_o` is 0 and `ram_we_o` is 0.
- R2: Slot i (0..4) has its address register at register address 2069+i and its data register at 2064+i. On a RAM write, `ram_addr_o` carries bits [9:0] of the 12-bit address field. `ram_wdata_o` carries bits [27:0] of the 40-bit data field. Higher bits are dropped.
- R3: A write to a slot's data register marks that slot pending. A write to its address register alone does not.
- R4: A write to register 2076 with bit 2 of the data set requests a transfer, and `busy_o` rises on the next cycle. With bit 2 clear, the write has no effect.
- R5: The RAM writes of a transfer start at instruction cycle 1019 of the first frame that begins after the request. They never occur in the frame in which the request was made, even when the request comes after cycle 1019.
- R6: Pending slots are written in ascending slot order, one per cycle, on consecutive instruction cycles.
- R7: Only pending slots are written. A slot stops being pending once it is written, so a later request with no new data writes produce no RAM writes.
- R8: `busy_o` falls on the cycle after the last pending slot is written. With nothing pending, it falls on the cycle after cycle 1019.
- R9: While `busy_o` is 1, writes to slot registers and to the control register are ignored.
- R10: Every RAM write happens at an instruction count in 1019..1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 12 | Host register address |
| wr_data_i | input | 40 | Host register write data |
| frame_start_i | input | 1 | One-cycle pulse at instruction cycle 0 of each frame |
| instr_cnt_i | input | 10 | Instruction cycle within the frame |
| busy_o | output | 1 | A transfer is pending or in progress |
| ram_we_o | output | 1 | Parameter RAM write enable |
| ram_addr_o | output | 10 | Parameter RAM write address |
| ram_wdata_o | output | 28 | Parameter RAM write data |

## Verification
The assertions assume the following about the inputs:
- The instruction counter steps by one every clock and wraps from 1023 to 0.
- `frame_start_i` pulses exactly when the counter reads 0.

The stimulus keeps to this: a single free-running frame generator drives both signals. The assertions also assume that host writes are one-cycle strobes to decoded addresses. The bench issues every write through one write task, so this always holds.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_WAIT  = 2'd1,
    SCH_ARMED = 2'd2
  } sched_state_e;
endpackage

// File: rtl/safeload_decode.sv
module safeload_decode #(
  parameter int N_SLOTS   = 5,
  parameter int REG_AW    = 12,
  parameter int DATA_BASE = 2064,
  parameter int ADDR_BASE = 2069,
  parameter int CTRL_ADDR = 2076
) (
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic              init_bit_i,
  input  logic              busy_i,
  output logic [N_SLOTS-1:0] addr_we_o,
  output logic [N_SLOTS-1:0] data_we_o,
  output logic              init_wr_o
);
  logic accept;
  assign accept = wr_en_i && !busy_i;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign addr_we_o[i] = accept && (wr_addr_i == REG_AW'(ADDR_BASE + i));
    assign data_we_o[i] = accept && (wr_addr_i == REG_AW'(DATA_BASE + i));
  end

  assign init_wr_o = accept && init_bit_i && (wr_addr_i == REG_AW'(CTRL_ADDR));
endmodule

// File: rtl/safeload_slots.sv
module safeload_slots #(
  parameter int N_SLOTS = 5,
  parameter int RAM_AW  = 10,
  parameter int RAM_DW  = 28
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          busy_i,
  input  logic [N_SLOTS-1:0]            addr_we_i,
  input  logic [N_SLOTS-1:0]            data_we_i,
  input  logic [RAM_AW-1:0]             addr_in_i,
  input  logic [RAM_DW-1:0]             data_in_i,
  input  logic [N_SLOTS-1:0]            clr_i,
  output logic [N_SLOTS-1:0]            valid_o,
  output logic [N_SLOTS-1:0][RAM_AW-1:0] addr_o,
  output logic [N_SLOTS-1:0][RAM_DW-1:0] data_o
);
  logic [N_SLOTS-1:0]             valid_q;
  logic [N_SLOTS-1:0][RAM_AW-1:0] addr_q;
  logic [N_SLOTS-1:0][RAM_DW-1:0] data_q;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
        data_q[i]  <= '0;
      end else begin
        if (addr_we_i[i]) addr_q[i] <= addr_in_i;
        if (data_we_i[i]) data_q[i] <= data_in_i;
        if (data_we_i[i])   valid_q[i] <= 1'b1;
        else if (clr_i[i])  valid_q[i] <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R7: a committed slot is no longer pending
  a_r7_clear_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((valid_q & $past(clr_i)) == '0));
  // R3: pending only ever appears after a data write
  a_r3_set_by_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((valid_q & ~$past(valid_q)) != '0) |-> $past(|data_we_i));
  // R9: staged content frozen while busy
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/safeload_pick.sv
module safeload_pick #(
  parameter int N_SLOTS = 5,
  localparam int SEL_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [N_SLOTS-1:0] valid_i,
  output logic [N_SLOTS-1:0] grant_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               any_o,
  output logic               more_o
);
  always_comb begin
    grant_o = '0;
    sel_o   = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        sel_o = SEL_W'(i);
      end
    end
  end

  assign any_o  = |valid_i;
  assign more_o = |(valid_i & ~grant_o);
endmodule

// File: rtl/safeload_sched.sv
module safeload_sched
  import safeload_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int START_CYC = 1019
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_wr_i,
  input  logic             frame_start_i,
  input  logic [CNT_W-1:0] instr_cnt_i,
  input  logic             more_i,
  output logic             window_o,
  output logic             busy_o
);
  sched_state_e state_q;
  logic done;

  assign window_o = (state_q == SCH_ARMED) && (instr_cnt_i >= CNT_W'(START_CYC));
  assign done     = window_o && !more_i;
  assign busy_o   = (state_q != SCH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SCH_IDLE;
    else begin
      unique case (state_q)
        SCH_IDLE:  if (init_wr_i) state_q <= SCH_WAIT;
        SCH_WAIT:  if (frame_start_i) state_q <= SCH_ARMED;
        SCH_ARMED: if (done) state_q <= SCH_IDLE;
        default:   state_q <= SCH_IDLE;
      endcase
    end
  end

  // R4: busy only follows an initiate request
  a_r4_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(init_wr_i));
  // R5: arming only on a frame boundary
  a_r5_arm_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == SCH_ARMED) |-> $past(frame_start_i));
  // R8: busy ends only inside the reserved window
  a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(instr_cnt_i) >= CNT_W'(START_CYC)));
endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl #(
  parameter int N_SLOTS   = 5,
  parameter int RAM_AW    = 10,
  parameter int RAM_DW    = 28,
  parameter int REG_AW    = 12,
  parameter int REG_DW    = 40,
  parameter int FRAME_CYC = 1024,
  parameter int DATA_BASE = 2064,
  parameter int ADDR_BASE = 2069,
  parameter int CTRL_ADDR = 2076,
  parameter int INIT_BIT  = 2,
  localparam int CNT_W    = $clog2(FRAME_CYC),
  localparam int START_CYC = FRAME_CYC - N_SLOTS,
  localparam int SEL_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  input  logic              frame_start_i,
  input  logic [CNT_W-1:0]  instr_cnt_i,
  output logic              busy_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [RAM_DW-1:0] ram_wdata_o
);
  logic [N_SLOTS-1:0] addr_we, data_we, valid, grant, clr;
  logic [N_SLOTS-1:0][RAM_AW-1:0] addr_arr;
  logic [N_SLOTS-1:0][RAM_DW-1:0] data_arr;
  logic [SEL_W-1:0] sel;
  logic init_wr, any, more, window, busy;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[REG_DW-1:RAM_DW];

  safeload_decode #(
    .N_SLOTS(N_SLOTS), .REG_AW(REG_AW), .DATA_BASE(DATA_BASE),
    .ADDR_BASE(ADDR_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .init_bit_i(wr_data_i[INIT_BIT]),
    .busy_i(busy), .addr_we_o(addr_we), .data_we_o(data_we), .init_wr_o(init_wr)
  );

  safeload_slots #(.N_SLOTS(N_SLOTS), .RAM_AW(RAM_AW), .RAM_DW(RAM_DW)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy),
    .addr_we_i(addr_we), .data_we_i(data_we),
    .addr_in_i(wr_data_i[RAM_AW-1:0]), .data_in_i(wr_data_i[RAM_DW-1:0]),
    .clr_i(clr), .valid_o(valid), .addr_o(addr_arr), .data_o(data_arr)
  );

  safeload_pick #(.N_SLOTS(N_SLOTS)) u_pick (
    .valid_i(valid), .grant_o(grant), .sel_o(sel), .any_o(any), .more_o(more)
  );

  safeload_sched #(.CNT_W(CNT_W), .START_CYC(START_CYC)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_wr_i(init_wr),
    .frame_start_i(frame_start_i), .instr_cnt_i(instr_cnt_i),
    .more_i(more), .window_o(window), .busy_o(busy)
  );

  assign clr         = grant & {N_SLOTS{window}};
  assign ram_we_o    = window && any;
  assign ram_addr_o  = addr_arr[sel];
  assign ram_wdata_o = data_arr[sel];
  assign busy_o      = busy;

  // R10: RAM writes only in the reserved trailing cycles
  a_r10_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (instr_cnt_i >= CNT_W'(START_CYC)));
  // R8: a write always happens under busy
  a_r8_we_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> busy_o);
endmodule

// File: tb/safeload_ctrl_tb.sv
module safeload_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [11:0] wr_addr = '0;
  logic [39:0] wr_data = '0;
  logic frame_start = 0;
  logic [9:0] instr_cnt = '0;
  logic busy, ram_we;
  logic [9:0] ram_addr;
  logic [27:0] ram_wdata;

  int checks = 0, errors = 0, frame_idx = 0;
  int n_log = 0;
  int lg_frame[16], lg_cnt[16];
  logic [9:0] lg_addr[16];
  logic [27:0] lg_data[16];

  always #4 clk = ~clk;

  safeload_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .frame_start_i(frame_start), .instr_cnt_i(instr_cnt),
    .busy_o(busy), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata)
  );

  // frame generator
  initial begin
    instr_cnt = 10'd0; frame_start = 1'b1;
    forever begin
      @(negedge clk);
      instr_cnt = (instr_cnt == 10'd1023) ? 10'd0 : instr_cnt + 10'd1;
      frame_start = (instr_cnt == 10'd0);
      if (instr_cnt == 10'd0) frame_idx++;
    end
  end

  // RAM write monitor, sampled just before the rising edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && ram_we) begin
        if (n_log < 16) begin
          lg_frame[n_log] = frame_idx; lg_cnt[n_log] = int'(instr_cnt);
          lg_addr[n_log] = ram_addr; lg_data[n_log] = ram_wdata;
        end
        n_log++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_cnt(int v);
    do tick(); while (int'(instr_cnt) != v);
  endtask

  task automatic host_wr(int a, logic [39:0] d);
    tick();
    wr_en = 1'b1; wr_addr = 12'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic stage(int slot, logic [11:0] a, logic [39:0] d);
    host_wr(2069 + slot, {28'h0, a});
    host_wr(2064 + slot, d);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) tick();
    tick();
  endtask

  // compare n expected writes: slots listed in exp_a/exp_d, frame expf
  task automatic check_log(string req, int n, int expf,
                           logic [9:0] exp_a[5], logic [27:0] exp_d[5]);
    chk(n_log == n, req, "write count", n_log, n);
    for (int k = 0; k < n && k < n_log; k++) begin
      chk(lg_frame[k] == expf, req, "commit frame", lg_frame[k], expf);
      chk(lg_cnt[k] == 1019 + k, req, "commit cycle", lg_cnt[k], 1019 + k);
      chk(lg_addr[k] == exp_a[k], req, "ram addr", lg_addr[k], exp_a[k]);
      chk(lg_data[k] == exp_d[k], req, "ram data", lg_data[k], exp_d[k]);
    end
  endtask

  // R1
  task automatic t_reset();
    tick();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(ram_we == 1'b0, "R1", "ram_we after reset", ram_we, 0);
  endtask

  // R2 R4 R5 R6 R8 R10: all five slots, high field bits set
  task automatic t_full();
    logic [9:0] ea[5]; logic [27:0] ed[5]; int f0;
    wait_cnt(40);
    for (int i = 0; i < 5; i++) begin
      stage(i, 12'hC00 + 12'(37 * i), {12'hFAB, 28'h1234560 + 28'(i)});
      ea[i] = 10'(37 * i); ed[i] = 28'h1234560 + 28'(i);
    end
    n_log = 0; f0 = frame_idx;
    host_wr(2076, 40'h4);
    chk(busy == 1'b1, "R4", "busy after initiate", busy, 1);
    wait_idle();
    chk(busy == 1'b0, "R8", "busy after commit", busy, 0);
    check_log("R2_R5_R6", 5, f0 + 1, ea, ed);
  endtask

  // R3 R7: sparse, address-only slot 4 not sent
  task automatic t_sparse();
    logic [9:0] ea[5]; logic [27:0] ed[5]; int f0;
    wait_cnt(100);
    host_wr(2069 + 4, 40'h3FF);
    stage(3, 12'h033, 40'h0000333);
    stage(1, 12'h011, 40'h0000111);
    ea[0] = 10'h011; ed[0] = 28'h111; ea[1] = 10'h033; ed[1] = 28'h333;
    ea[2] = 0; ea[3] = 0; ea[4] = 0; ed[2] = 0; ed[3] = 0; ed[4] = 0;
    n_log = 0; f0 = frame_idx;
    host_wr(2076, 40'h4);
    wait_idle();
    check_log("R3_R6_R7", 2, f0 + 1, ea, ed);
  endtask

  // R5: initiate after cycle 1019 waits for the next frame
  task automatic t_late();
    logic [9:0] ea[5]; logic [27:0] ed[5]; int f0;
    stage(0, 12'h2AA, 40'h00ABCDEF);
    ea = '{10'h2AA, 0, 0, 0, 0}; ed = '{28'h0ABCDEF, 0, 0, 0, 0};
    wait_cnt(1020);
    n_log = 0; f0 = frame_idx;
    host_wr(2076, 40'h4);
    wait_idle();
    check_log("R5", 1, f0 + 1, ea, ed);
  endtask

  // R4: control write with bit 2 clear does nothing; then R9 hold-off
  task automatic t_ctrl_and_busy();
    logic [9:0] ea[5]; logic [27:0] ed[5]; int f0;
    wait_cnt(10);
    stage(2, 12'h123, 40'h0222222);
    n_log = 0;
    host_wr(2076, 40'h1FB);
    for (int i = 0; i < 1100; i++) tick();
    chk(busy == 1'b0, "R4", "busy after bit-clear write", busy, 0);
    chk(n_log == 0, "R4", "writes after bit-clear write", n_log, 0);
    wait_cnt(20);
    n_log = 0; f0 = frame_idx;
    host_wr(2076, 40'h4);
    host_wr(2064 + 2, 40'h5);
    host_wr(2069 + 2, 40'h7);
    host_wr(2064 + 0, 40'h9);
    ea = '{10'h123, 0, 0, 0, 0}; ed = '{28'h0222222, 0, 0, 0, 0};
    wait_idle();
    check_log("R9", 1, f0 + 1, ea, ed);
    // R7 R8: nothing pending, transfer still completes in the window
    wait_cnt(30);
    n_log = 0;
    host_wr(2076, 40'h4);
    chk(busy == 1'b1, "R8", "busy on empty transfer", busy, 1);
    wait_idle();
    chk(busy == 1'b0, "R8", "busy cleared on empty transfer", busy, 0);
    chk(n_log == 0, "R7", "writes on empty transfer", n_log, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_sparse();
    t_late();
    t_ctrl_and_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule